// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Break Handling

This block receives asynchronous serial frames on a single input line. It is clocked by the system clock and advances its bit timing only on a one-cycle enable tick. An external divider generates this tick at either 16 or 8 times the bit rate, and a mode input tells the receiver which ratio is in use. The line first passes through a synchronizer. The receiver finds the falling edge of the start bit on a tick and takes that tick as the origin of its bit timing. It then samples every bit at its centre.

A frame has these parts, in line order:
- one start bit (low),
- eight data bits, least significant first,
- an optional parity bit (even or odd),
- one stop bit (high).

Frames that are received without error are written into a 16-entry receive queue. The queue is read by a pop strobe, and its output always shows the oldest byte. A frame with a wrong stop bit or a wrong parity bit sets a sticky error flag and is not stored. A line held low long enough for a whole frame is treated as a break. While the break lasts, the receiver keeps framing the line but writes nothing to the queue. The synchronized line level is also available at a port, so that software can confirm a break after it sees a framing error.

Top module: `uart_os_rx`

## Requirements
- R1: After reset the queue is empty: `fifo_count` is 0, `fifo_empty` is 1 and `fifo_full` is 0. `frame_err`, `parity_err`, `overrun` and `break_state` are all 0, and `rxd_level` is 1.
- R2: With `mode_x8`=0 a bit lasts 16 ticks; with `mode_x8`=1 it lasts 8 ticks. A frame is a low start bit, eight data bits sent LSB first, a parity bit only when `par_en`=1, and one stop bit.
- R3: A start is seen on a tick where the synchronized line is low and the previous tick saw it high. Counting that tick as pulse 1, the start bit is sampled on pulse 8 (16x mode) or pulse 4 (8x mode). Each later bit is sampled exactly one bit time after the previous sample.
- R4: If the line is high when the start bit is sampled, the frame is dropped as a glitch and the receiver goes back to idle. No byte is stored and no flag is set.
- R5: When `par_en`=1, the expected parity bit is the XOR of the eight data bits, inverted when `par_odd`=1. A mismatch sets `parity_err` and the byte is not stored.
- R6: A stop bit sampled low sets `frame_err` and the byte is not stored.
- R7: `frame_err`, `parity_err` and `overrun` stay set until `err_clr` is pulsed.
- R8: A frame whose data bits are all zero and whose stop bit is low sets `break_state`. The first tick that samples the line high clears `break_state` and drops any frame in progress.
- R9: While `break_state` is 1, nothing is written to the queue. The receiver still frames the low line back to back, so `frame_err` becomes set again after a clear.
- R10: `rxd_level` is `rxd` delayed by the synchronizer, which is two clock cycles.
- R11: The queue holds 16 bytes in arrival order. `rd_data` always shows the oldest byte, `rd_en` removes it, and `rd_en` on an empty queue changes nothing.
- R12: A good frame that completes while the queue is full is discarded and sets `overrun`; the stored bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, one cycle per base pulse |
| mode_x8 | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| rxd | input | 1 | Serial input line |
| err_clr | input | 1 | Clears the sticky error flags |
| rd_en | input | 1 | Pops the oldest byte |
| rd_data | output | 8 | Oldest byte in the queue |
| fifo_count | output | 5 | Number of stored bytes |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| frame_err | output | 1 | Sticky stop-bit error |
| parity_err | output | 1 | Sticky parity error |
| overrun | output | 1 | Sticky queue overrun |
| break_state | output | 1 | Break condition active |
| rxd_level | output | 1 | Synchronized line level |

## Verification
The bench builds the block with its defaults: 16x top ratio, a 16-entry queue and a two-stage synchronizer. Because the data width is 8 bits, every byte value can be swept in 8x mode with both parity senses, and a subset can be swept in 16x mode. Because the queue holds 16 entries, overrun is reached after seventeen frames. The glitch tests hold the start bit low for exactly one tick fewer than the sample point, and then for exactly the sample point, in both modes. This places the mid-bit sample to the tick.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned RX_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // ticks per bit for the selected ratio
  function automatic int unsigned bit_ticks(input logic x8, input int unsigned hi);
    return x8 ? (hi >> 1) : hi;
  endfunction

  // parity bit the transmitter is expected to send
  function automatic logic exp_parity(input logic [RX_DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_sample_fsm.sv
module rx_sample_fsm
  import uart_rx_pkg::*;
#(
  parameter  int unsigned OS_HI = 16,
  localparam int unsigned CW    = $clog2(OS_HI) + 1,
  localparam int unsigned BW    = $clog2(RX_DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             line,
  input  logic             mode_x8,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             brk,
  input  logic             abort,
  output logic             start_det,
  output logic             sample_stb,
  output logic             start_sample,
  output logic             frame_done,
  output logic [RX_DW-1:0] frame_data,
  output logic             frame_ferr,
  output logic             frame_perr,
  output rx_state_e        state
);
  logic [CW-1:0] cnt;
  logic          prev_line;
  logic [RX_DW-1:0] shreg;
  logic [BW-1:0] bit_idx;
  logic          par_bit;
  int unsigned   n_bit;
  int unsigned   target;

  always_comb begin
    n_bit  = bit_ticks(mode_x8, OS_HI);
    target = (state == ST_START) ? (n_bit >> 1) : n_bit;
  end

  // falling edge, or a still-low line while the break persists
  assign start_det    = (state == ST_IDLE) && tick && !line && (prev_line || brk);
  assign sample_stb   = tick && (state != ST_IDLE) && !abort && (cnt == CW'(target - 1));
  assign start_sample = sample_stb && (state == ST_START);
  assign frame_done   = sample_stb && (state == ST_STOP);
  assign frame_data   = shreg;
  assign frame_ferr   = !line;
  assign frame_perr   = par_en && (par_bit != exp_parity(shreg, par_odd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_line <= 1'b1;
    else if (tick) prev_line <= line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      bit_idx <= '0;
      par_bit <= 1'b0;
    end else if (abort) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (start_det) begin
      state <= ST_START;
      cnt   <= CW'(1);
    end else if (tick && state != ST_IDLE) begin
      if (sample_stb) begin
        cnt <= '0;
        unique case (state)
          ST_START: begin
            state   <= line ? ST_IDLE : ST_DATA;
            bit_idx <= '0;
          end
          ST_DATA: begin
            shreg <= {line, shreg[RX_DW-1:1]};
            if (bit_idx == BW'(RX_DW - 1)) state <= par_en ? ST_PAR : ST_STOP;
            else                           bit_idx <= bit_idx + 1'b1;
          end
          ST_PAR: begin
            par_bit <= line;
            state   <= ST_STOP;
          end
          ST_STOP: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter  int unsigned DEPTH = 16,
  parameter  int unsigned W     = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wrap_inc(wptr);
      if (do_rd) rptr <= wrap_inc(rptr);
      if (do_wr && !do_rd)      count <= count + 1'b1;
      else if (do_rd && !do_wr) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_rx_pkg::*;
#(
  parameter  int unsigned OS_HI       = 16,
  parameter  int unsigned FIFO_DEPTH  = 16,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W       = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode_x8,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             rxd,
  input  logic             err_clr,
  input  logic             rd_en,
  output logic [RX_DW-1:0] rd_data,
  output logic [CNT_W-1:0] fifo_count,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic             frame_err,
  output logic             parity_err,
  output logic             overrun,
  output logic             break_state,
  output logic             rxd_level
);
  logic             line;
  logic             abort;
  logic             start_det, sample_stb, start_sample, frame_done;
  logic [RX_DW-1:0] frame_data;
  logic             frame_ferr, frame_perr;
  rx_state_e        state;
  logic             frame_good, push, ovf_evt, brk_enter;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line)
  );

  rx_sample_fsm #(.OS_HI(OS_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line),
    .mode_x8(mode_x8), .par_en(par_en), .par_odd(par_odd),
    .brk(break_state), .abort(abort),
    .start_det(start_det), .sample_stb(sample_stb), .start_sample(start_sample),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_ferr(frame_ferr), .frame_perr(frame_perr), .state(state)
  );

  assign abort      = break_state && tick && line;
  assign frame_good = frame_done && !frame_ferr && !frame_perr;
  assign push       = frame_good && !break_state && !fifo_full;
  assign ovf_evt    = frame_good && !break_state && fifo_full;
  assign brk_enter  = frame_done && frame_ferr && (frame_data == '0);
  assign rxd_level  = line;

  rx_fifo #(.DEPTH(FIFO_DEPTH), .W(RX_DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(push), .wdata(frame_data), .rd(rd_en),
    .rdata(rd_data), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      break_state <= 1'b0;
      frame_err   <= 1'b0;
      parity_err  <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      if (brk_enter)  break_state <= 1'b1;
      else if (abort) break_state <= 1'b0;
      frame_err  <= (frame_err  && !err_clr) || (frame_done && frame_ferr);
      parity_err <= (parity_err && !err_clr) || (frame_done && frame_perr);
      overrun    <= (overrun    && !err_clr) || ovf_evt;
    end
  end
endmodule

module uart_os_rx_chk
  import uart_rx_pkg::*;
#(
  parameter int unsigned OS_HI      = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             mode_x8,
  input logic             line,
  input logic             err_clr,
  input logic             rd_en,
  input logic             start_det,
  input logic             sample_stb,
  input logic             start_sample,
  input logic             frame_done,
  input logic [RX_DW-1:0] frame_data,
  input logic             frame_ferr,
  input logic             frame_perr,
  input rx_state_e        state,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_full,
  input logic             frame_err,
  input logic             overrun,
  input logic             break_state
);
  logic [7:0] gap;
  int unsigned n_chk;

  assign n_chk = mode_x8 ? (OS_HI / 2) : OS_HI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       gap <= '0;
    else if (start_det || sample_stb) gap <= '0;
    else if (tick)                    gap <= gap + 1'b1;
  end

  assert_start_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_sample |-> (32'(gap) == (n_chk / 2) - 2));

  assert_bit_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !start_sample) |-> (32'(gap) == n_chk - 1));

  assert_glitch_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sample && line) |=> (state == ST_IDLE));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clr) |=> frame_err);

  assert_break_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_ferr && frame_data == '0) |=> break_state);

  assert_break_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (break_state && tick && line) |=> (!break_state && state == ST_IDLE));

  assert_no_push_in_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    break_state |=> (fifo_count <= $past(fifo_count)));

  assert_fifo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_count) <= FIFO_DEPTH));

  assert_overrun_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_ferr && !frame_perr && !break_state && fifo_full && !rd_en)
      |=> (overrun && fifo_count == $past(fifo_count)));
endmodule

bind uart_os_rx uart_os_rx_chk #(
  .OS_HI(OS_HI), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_x8(mode_x8), .line(line),
  .err_clr(err_clr), .rd_en(rd_en), .start_det(start_det), .sample_stb(sample_stb),
  .start_sample(start_sample), .frame_done(frame_done), .frame_data(frame_data),
  .frame_ferr(frame_ferr), .frame_perr(frame_perr), .state(state),
  .fifo_count(fifo_count), .fifo_full(fifo_full), .frame_err(frame_err),
  .overrun(overrun), .break_state(break_state)
);

// File: tb/uart_os_rx_tb.sv
`timescale 1ns/1ps
module uart_os_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, mode_x8 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic       rxd = 1'b1, err_clr = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] fifo_count;
  logic       fifo_empty, fifo_full, frame_err, parity_err, overrun, break_state, rxd_level;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_os_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_x8(mode_x8), .par_en(par_en),
    .par_odd(par_odd), .rxd(rxd), .err_clr(err_clr), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .frame_err(frame_err), .parity_err(parity_err),
    .overrun(overrun), .break_state(break_state), .rxd_level(rxd_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic ref_par(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    return ((ones % 2) == 1) ^ odd;
  endfunction

  function automatic int ratio();
    return mode_x8 ? 8 : 16;
  endfunction

  task automatic pulse();
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop_v, input logic flip);
    hold(1'b0, ratio());
    for (int i = 0; i < 8; i++) hold(d[i], ratio());
    if (par_en) hold(ref_par(d, par_odd) ^ flip, ratio());
    hold(stop_v, ratio());
    hold(1'b1, 2);
  endtask

  task automatic pop_chk(input string req, input int exp);
    @(negedge clk);
    chk(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", fifo_count, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 flags", {frame_err, parity_err, overrun, break_state}, 0);
    chk("R1 R10 rxd_level", rxd_level, 1);

    // R10 synchronizer delay
    @(negedge clk); rxd = 1'b0;
    @(negedge clk); chk("R10 level after 1 clk", rxd_level, 1);
    @(negedge clk); chk("R10 level after 2 clk", rxd_level, 0);
    rxd = 1'b1;
    hold(1'b1, 4);

    // R2 R5 8x sweep of every byte, parity sense alternating
    mode_x8 = 1'b1; par_en = 1'b1;
    for (int i = 0; i < 256; i++) begin
      par_odd = i[0];
      send_frame(8'(i), 1'b1, 1'b0);
      chk("R2 R5 8x count", fifo_count, 1);
      pop_chk("R2 R5 8x byte", i);
    end
    chk("R5 no parity error in sweep", parity_err, 0);

    // R2 16x sweep without parity
    mode_x8 = 1'b0; par_en = 1'b0;
    for (int i = 0; i < 24; i++) begin
      send_frame(8'((i * 11) ^ 8'hA5), 1'b1, 1'b0);
      pop_chk("R2 16x byte", (i * 11) ^ 8'hA5);
    end
    chk("R2 16x empty", fifo_empty, 1);

    // R3 R4 16x glitch boundary: 7 low pulses rejected, 8 accepted
    hold(1'b0, 7); hold(1'b1, 30);
    chk("R4 16x glitch no byte", fifo_count, 0);
    chk("R4 16x glitch no flag", {frame_err, parity_err}, 0);
    hold(1'b0, 8); hold(1'b1, 16 * 10);
    chk("R3 16x start at pulse 8", fifo_count, 1);
    pop_chk("R3 16x byte", 8'hFF);

    // R3 R4 8x glitch boundary: 3 rejected, 4 accepted
    mode_x8 = 1'b1;
    hold(1'b0, 3); hold(1'b1, 20);
    chk("R4 8x glitch no byte", fifo_count, 0);
    hold(1'b0, 4); hold(1'b1, 8 * 10);
    chk("R3 8x start at pulse 4", fifo_count, 1);
    pop_chk("R3 8x byte", 8'hFF);

    // R5 R7 bad parity, stickiness, clear
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h3C, 1'b1, 1'b1);
    chk("R5 parity_err", parity_err, 1);
    chk("R5 not stored", fifo_count, 0);
    chk("R5 no frame_err", frame_err, 0);
    send_frame(8'h42, 1'b1, 1'b0);
    chk("R7 parity_err sticky", parity_err, 1);
    pop_chk("R7 good byte", 8'h42);
    clear_flags();
    chk("R7 cleared", parity_err, 0);

    // R6 bad stop with nonzero data
    mode_x8 = 1'b0; par_en = 1'b0;
    send_frame(8'h81, 1'b0, 1'b0);
    chk("R6 frame_err", frame_err, 1);
    chk("R6 not stored", fifo_count, 0);
    chk("R6 R8 no break", break_state, 0);
    clear_flags();
    chk("R7 frame_err cleared", frame_err, 0);

    // R8 R9 break, 16x odd parity
    par_en = 1'b1; par_odd = 1'b1;
    hold(1'b0, 16 * 11);
    chk("R8 break entered", break_state, 1);
    chk("R8 frame_err", frame_err, 1);
    chk("R8 odd parity also flagged", parity_err, 1);
    chk("R10 level low in break", rxd_level, 0);
    clear_flags();
    chk("R9 cleared in break", frame_err, 0);
    hold(1'b0, 16 * 22);
    chk("R9 receiver keeps framing", frame_err, 1);
    chk("R9 nothing stored", fifo_count, 0);
    chk("R9 still in break", break_state, 1);
    hold(1'b1, 3);
    chk("R8 break left", break_state, 0);
    hold(1'b1, 16 * 12);
    chk("R8 frame abandoned", fifo_count, 0);
    clear_flags();
    send_frame(8'h5A, 1'b1, 1'b0);
    pop_chk("R8 good byte after break", 8'h5A);
    chk("R8 no new error", {frame_err, parity_err}, 0);

    // R11 R12 overrun, 8x no parity
    mode_x8 = 1'b1; par_en = 1'b0;
    for (int i = 0; i < 17; i++) send_frame(8'(8'h10 + i), 1'b1, 1'b0);
    chk("R12 count full", fifo_count, 16);
    chk("R12 full", fifo_full, 1);
    chk("R12 overrun", overrun, 1);
    for (int i = 0; i < 16; i++) pop_chk("R11 R12 order", 8'h10 + i);
    chk("R11 empty", fifo_empty, 1);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R11 pop on empty count", fifo_count, 0);
    chk("R11 pop on empty flag", fifo_empty, 1);
    chk("R7 overrun sticky", overrun, 1);
    clear_flags();
    chk("R7 overrun cleared", overrun, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule